// File: doc/BRIEF.md
# Exception Detection and Vectoring Unit

This block sits beside a single-cycle processor core and watches the instruction that is being executed in the current cycle. It raises an exception in two cases: the decoder reports an opcode that it does not recognise, or an add, addi or sub produces a signed result that does not fit in the register width. A faulting instruction is cancelled in the same cycle. Its register-file and data-memory write strobes are forced low, and the core's next-PC multiplexer is told to load a handler address in place of the normal next PC.

At the clock edge that ends the faulting cycle, the block stores the address of the faulting instruction in an exception PC register. It derives that address by taking the already-incremented PC and subtracting four. The same edge loads a cause register with a single flag that names the reason. A mode input selects where the core goes next. In vectored mode each exception kind has its own handler entry, spaced a fixed stride apart from a base address. In common mode every exception goes to one shared entry, and software reads the cause register to tell the kinds apart.

Top module: `exc_unit`

## Requirements
- R1: After reset, `epc` and `cause` are zero. `redirect_valid` is low whenever `op_undef` is low and no overflow condition is present.
- R2: With `op_add` high (used for add and addi), an exception is raised when `alu_a` and `alu_b` have equal sign bits and bit 31 of `alu_res` differs from them.
- R3: With `op_sub` high, an exception is raised when the sign bits of `alu_a` and `alu_b` differ and bit 31 of `alu_res` differs from the sign bit of `alu_a`. This rule also applies when `alu_b` is 0x80000000.
- R4: When neither `op_add` nor `op_sub` is high, the operand and result values never raise an exception.
- R5: In a cycle with an exception, `rf_we` and `dm_we` are low. In any other cycle they equal `rf_we_in` and `dm_we_in`.
- R6: At the clock edge that ends an exception cycle, `epc` takes the value `pc_plus4 - 4`, computed modulo 2^32.
- R7: At that same edge, `cause` (8 bits) is overwritten with exactly one set bit: bit 2 for an undefined instruction, or bit 5 for arithmetic overflow.
- R8: With `vec_mode` = 1, `redirect_pc` is 0xC0000000 for an undefined instruction and 0xC0000020 for an overflow.
- R9: With `vec_mode` = 0, `redirect_pc` is 0x80000180 for both exception kinds. The cause bits are the same as in R7.
- R10: If an undefined opcode and an overflow condition occur in the same cycle, the undefined instruction wins, for both the target address and the cause bit.
- R11: In cycles without an exception, `epc` and `cause` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_mode | input | 1 | 1 = handler address per exception kind, 0 = one shared handler |
| op_undef | input | 1 | Decoder reports an unrecognised opcode |
| op_add | input | 1 | Current instruction is add or addi |
| op_sub | input | 1 | Current instruction is sub |
| alu_a | input | 32 | First ALU operand |
| alu_b | input | 32 | Second ALU operand (register or sign-extended immediate) |
| alu_res | input | 32 | ALU result |
| pc_plus4 | input | 32 | Incremented PC of the current instruction |
| rf_we_in | input | 1 | Register-file write request from the control unit |
| dm_we_in | input | 1 | Data-memory write request from the control unit |
| rf_we | output | 1 | Register-file write strobe after cancellation |
| dm_we | output | 1 | Data-memory write strobe after cancellation |
| redirect_valid | output | 1 | Next PC must be taken from `redirect_pc` |
| redirect_pc | output | 32 | Handler entry address |
| epc | output | 32 | Address of the last faulting instruction |
| cause | output | 8 | One-hot reason for the last exception |

## Verification
The bench uses the default parameters: a 32-bit datapath, an 8-bit cause register with flags at bits 2 and 5, a vector base of 0xC0000000 with a 0x20 stride, and a shared entry at 0x80000180. With a 32-bit width, the directed operands can sit exactly on the 0x7FFFFFFF / 0x80000000 boundary. They cover the case where subtracting 0x80000000 overflows even though its negation has the same sign. Both handler modes are exercised, along with the case where the undefined-opcode and overflow conditions arrive together. Random instructions with mixed modes then compare every output against a 64-bit arithmetic model on every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Kind of exception raised by the current instruction; the encoding
    // order is also the vector slot order.
    typedef enum logic [1:0] {
        EXC_UNDEF = 2'd0,
        EXC_OVF   = 2'd1,
        EXC_NONE  = 2'd3
    } exc_kind_e;

endpackage

// File: rtl/ovf_detect.sv
module ovf_detect #(
    parameter int XLEN = 32
) (
    input  logic            is_add,
    input  logic            is_sub,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] res,
    output logic            ovf
);
    localparam int MSB = XLEN - 1;

    logic sa, sb, sr;
    logic add_ovf, sub_ovf;

    always_comb begin
        sa = a[MSB];
        sb = b[MSB];
        sr = res[MSB];
        // Same-sign operands whose sum flips sign.
        add_ovf = (sa == sb) && (sr != sa);
        // Opposite-sign operands whose difference leaves the sign of a.
        sub_ovf = (sa != sb) && (sr != sa);
        ovf = (is_add && add_ovf) || (is_sub && sub_ovf);
    end
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              CAUSE_W    = 8,
    parameter int              UND_BIT    = 2,
    parameter int              OVF_BIT    = 5,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020,
    parameter logic [XLEN-1:0] COMMON_VEC = 32'h8000_0180
) (
    input  logic               undef,
    input  logic               ovf,
    input  logic               vec_mode,
    output exc_kind_e          kind,
    output logic [XLEN-1:0]    target,
    output logic [CAUSE_W-1:0] flags
);
    localparam int              N_SLOTS = 2;
    localparam logic [XLEN-1:0] UND_VEC = VEC_BASE + XLEN'(int'(EXC_UNDEF)) * VEC_STRIDE;
    localparam logic [XLEN-1:0] OVF_VEC = VEC_BASE + XLEN'(int'(EXC_OVF)) * VEC_STRIDE;

    logic [XLEN-1:0] slot_addr [N_SLOTS];
    logic [XLEN-1:0] vec_addr;

    assign slot_addr[0] = UND_VEC;
    assign slot_addr[1] = OVF_VEC;

    always_comb begin
        // Undefined opcode outranks overflow.
        if (undef)    kind = EXC_UNDEF;
        else if (ovf) kind = EXC_OVF;
        else          kind = EXC_NONE;

        vec_addr = (kind == EXC_OVF) ? slot_addr[1] : slot_addr[0];
        target   = vec_mode ? vec_addr : COMMON_VEC;

        flags = '0;
        case (kind)
            EXC_UNDEF: flags[UND_BIT] = 1'b1;
            EXC_OVF:   flags[OVF_BIT] = 1'b1;
            default:   flags = '0;
        endcase
    end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
    import exc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              CAUSE_W    = 8,
    parameter int              UND_BIT    = 2,
    parameter int              OVF_BIT    = 5,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020,
    parameter logic [XLEN-1:0] COMMON_VEC = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_mode,
    input  logic               op_undef,
    input  logic               op_add,
    input  logic               op_sub,
    input  logic [XLEN-1:0]    alu_a,
    input  logic [XLEN-1:0]    alu_b,
    input  logic [XLEN-1:0]    alu_res,
    input  logic [XLEN-1:0]    pc_plus4,
    input  logic               rf_we_in,
    input  logic               dm_we_in,
    output logic               rf_we,
    output logic               dm_we,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
    } exc_state_t;

    exc_state_t st_d, st_q;

    logic               ovf_hit;
    exc_kind_e          kind;
    logic [XLEN-1:0]    target;
    logic [CAUSE_W-1:0] flags;
    logic               take;

    ovf_detect #(.XLEN(XLEN)) u_ovf (
        .is_add (op_add),
        .is_sub (op_sub),
        .a      (alu_a),
        .b      (alu_b),
        .res    (alu_res),
        .ovf    (ovf_hit)
    );

    exc_select #(
        .XLEN       (XLEN),
        .CAUSE_W    (CAUSE_W),
        .UND_BIT    (UND_BIT),
        .OVF_BIT    (OVF_BIT),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE),
        .COMMON_VEC (COMMON_VEC)
    ) u_sel (
        .undef    (op_undef),
        .ovf      (ovf_hit),
        .vec_mode (vec_mode),
        .kind     (kind),
        .target   (target),
        .flags    (flags)
    );

    always_comb begin
        take = (kind != EXC_NONE);
        st_d = st_q;
        if (take) begin
            st_d.epc   = pc_plus4 - PC_STEP;
            st_d.cause = flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rf_we          = rf_we_in && !take;
    assign dm_we          = dm_we_in && !take;
    assign redirect_valid = take;
    assign redirect_pc    = target;
    assign epc            = st_q.epc;
    assign cause          = st_q.cause;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
    parameter int              XLEN       = 32,
    parameter int              CAUSE_W    = 8,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_mode,
    input logic               op_undef,
    input logic               op_add,
    input logic               op_sub,
    input logic [XLEN-1:0]    pc_plus4,
    input logic               rf_we,
    input logic               dm_we,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [XLEN-1:0]    epc,
    input logic [CAUSE_W-1:0] cause
);
    assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!rf_we && !dm_we));

    assert_epc_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (epc == $past(pc_plus4) - XLEN'(INSN_BYTES)));

    assert_cause_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> ($countones(cause) == 1));

    assert_undef_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_undef && vec_mode) |-> (redirect_valid && redirect_pc == VEC_BASE));

    assert_plain_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_undef && !op_add && !op_sub) |-> !redirect_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> ($stable(epc) && $stable(cause)));
endmodule

bind exc_unit exc_unit_chk #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .INSN_BYTES (INSN_BYTES),
    .VEC_BASE   (VEC_BASE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .vec_mode       (vec_mode),
    .op_undef       (op_undef),
    .op_add         (op_add),
    .op_sub         (op_sub),
    .pc_plus4       (pc_plus4),
    .rf_we          (rf_we),
    .dm_we          (dm_we),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .cause          (cause)
);

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode = 1'b0;
    logic        op_undef = 1'b0, op_add = 1'b0, op_sub = 1'b0;
    logic [31:0] alu_a = '0, alu_b = '0, alu_res = '0, pc_plus4 = '0;
    logic        rf_we_in = 1'b0, dm_we_in = 1'b0;
    logic        rf_we, dm_we, redirect_valid;
    logic [31:0] redirect_pc, epc;
    logic [7:0]  cause;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [31:0] m_epc = '0;
    logic [7:0]  m_cause = '0;
    logic [31:0] pc = 32'h0040_0000;

    always #2 clk = ~clk;

    exc_unit u0 (
        .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .op_undef(op_undef),
        .op_add(op_add), .op_sub(op_sub), .alu_a(alu_a), .alu_b(alu_b),
        .alu_res(alu_res), .pc_plus4(pc_plus4), .rf_we_in(rf_we_in),
        .dm_we_in(dm_we_in), .rf_we(rf_we), .dm_we(dm_we),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .epc(epc), .cause(cause)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One instruction: drive after the falling edge, check combinational
    // outputs before the rising edge, check registers after it.
    task automatic step(string tag, bit vm, bit und, bit add, bit sub,
                        logic [31:0] a, logic [31:0] b, bit rfw, bit dmw);
        longint sa, sb, full;
        bit ovf, exc;
        logic [31:0] tgt;
        @(negedge clk);
        pc += 4;
        vec_mode = vm; op_undef = und; op_add = add; op_sub = sub;
        alu_a = a; alu_b = b; rf_we_in = rfw; dm_we_in = dmw;
        alu_res = sub ? a - b : a + b;
        pc_plus4 = pc;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        full = sub ? sa - sb : sa + sb;
        ovf = (add || sub) && (full > 64'sd2147483647 || full < -64'sd2147483648);
        exc = und || ovf;
        if (!vm)       tgt = 32'h8000_0180;
        else if (und)  tgt = 32'hC000_0000;
        else           tgt = 32'hC000_0020;
        #1;
        chk(tag, "redirect_valid", 32'(redirect_valid), 32'(exc));
        if (exc) chk(tag, "redirect_pc", redirect_pc, tgt);
        chk(tag, "rf_we", 32'(rf_we), 32'(rfw && !exc));
        chk(tag, "dm_we", 32'(dm_we), 32'(dmw && !exc));
        @(posedge clk);
        if (exc) begin
            m_epc   = pc - 32'd4;
            m_cause = und ? 8'h04 : 8'h20;
        end
        #1;
        chk(tag, "epc", epc, m_epc);
        chk(tag, "cause", 32'(cause), 32'(m_cause));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "epc after reset", epc, 32'h0);
        chk("R1", "cause after reset", 32'(cause), 32'h0);
        chk("R1", "no redirect in reset", 32'(redirect_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R1", 1, 0, 1, 0, 32'd5, 32'd7, 1, 0);
        step("R2", 1, 0, 1, 0, 32'h7FFF_FFFF, 32'h1, 1, 0);
        step("R2", 1, 0, 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0);
        step("R2", 1, 0, 1, 0, 32'h7FFF_FFFF, 32'h8000_0000, 1, 0);
        step("R3", 1, 0, 0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0);
        step("R3", 1, 0, 0, 1, 32'h0, 32'h8000_0000, 1, 0);
        step("R3", 1, 0, 0, 1, 32'h8000_0000, 32'h8000_0000, 1, 0);
        step("R3", 1, 0, 0, 1, 32'hFFFF_FFFF, 32'h8000_0000, 1, 0);
        step("R4", 1, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        step("R4", 0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 1);
        step("R5", 1, 1, 0, 0, 32'h100, 32'h8, 0, 1);
        step("R5", 1, 0, 1, 0, 32'h4000_0000, 32'h4000_0000, 1, 1);
        step("R6", 1, 0, 0, 1, 32'h8000_0000, 32'h1, 1, 0);
        step("R7", 1, 1, 0, 0, 32'h0, 32'h0, 1, 0);
        step("R8", 1, 1, 1, 0, 32'h1, 32'h1, 1, 0);
        step("R9", 0, 0, 1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        step("R9", 0, 1, 0, 0, 32'h3, 32'h3, 1, 0);
        step("R10", 1, 1, 1, 0, 32'h7FFF_FFFF, 32'h1, 1, 0);
        step("R10", 0, 1, 0, 1, 32'h0, 32'h8000_0000, 1, 0);
        step("R11", 1, 0, 1, 0, 32'h10, 32'h20, 1, 1);
        step("R11", 0, 0, 0, 1, 32'h10, 32'h20, 1, 0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            int sel;
            ra  = $urandom;
            rb  = $urandom;
            sel = $urandom_range(0, 2);
            if ($urandom_range(0, 3) == 0) ra[31:30] = 2'b01;
            if ($urandom_range(0, 3) == 0) rb[31:30] = 2'b10;
            step("R6", 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                 (sel == 1), (sel == 2), ra, rb,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule